// File: doc/BRIEF.md
# Reset-Time Clock-Mask Loader

This block runs once after the primary reset of a bus bridge is released. It reads a 16-bit clock-enable mask from an external parallel-in/serial-out shift register. For the whole capture it keeps the downstream (secondary) reset asserted. Two general-purpose I/O pins are borrowed to run the external register. One pin carries the register clock. The other carries a load/shift control, where 0 means load and 1 means shift. The serial data comes back on a dedicated mask input.

Capture takes 23 clock cycles. When it completes, the block does three things:
- it releases the secondary reset,
- it raises a done flag,
- it hands the I/O pins back to the general-purpose register file.

The captured mask is decoded into ten clock-enable outputs. Four of these come from two-bit slot-presence pairs and six come from single device bits. A board without the external register ties the mask input low to enable every clock, or high to disable every clock.

Top module: `clkmask_loader`

## Requirements
- R1: While `prim_rst_n` is low, the outputs take these values:
  - `sec_rst_out_n` = 0 and `done` = 0;
  - `clk_en` = all ones (every clock enabled);
  - `gpio_oe` = 4'b0101;
  - `gpio_out` = 0.
- R2: Capture starts on the first rising clock edge after `prim_rst_n` is released at which `sec_rst_in_n` is low. While `sec_rst_in_n` stays high, the block keeps waiting with `done` = 0.
- R3: The control pin `gpio_out[2]` has the following values:
  - 0 (load) while waiting and during capture cycles 0 and 1;
  - 1 (shift) during capture cycles 2 to 22.
- R4: The register clock pin `gpio_out[0]` is a forwarded copy of `clk`. It has a rising edge at the end of capture cycles 1 to 17: one load edge, then 16 shift edges. At every other time it is held low.
- R5: `mask_in` is sampled at the end of capture cycles 2 to 17, most significant bit first. The 16 samples form the captured mask.
- R6: Reset release and the done flag work as follows:
  - `sec_rst_out_n` stays 0 until the end of capture cycle 22, the 23rd cycle;
  - after that, `done` is 1 and `sec_rst_out_n` follows `sec_rst_in_n`;
  - `done` then stays 1 until the next primary reset.
- R7: For n = 0 to 3, `clk_en[n]` is 0 only when both mask bits 2n and 2n+1 are 1. Otherwise it is 1.
- R8: For n = 4 to 9, `clk_en[n]` equals the inverse of mask bit n+4, covering bits 8 to 13. Mask bits 14 and 15 have no effect.
- R9: `clk_en` stays all ones from reset until capture completes. It changes only at the edge that sets `done`.
- R10: The I/O pins are assigned as follows:
  - before `done` = 1: `gpio_oe` = 4'b0101, and `gpio_out[1]` and `gpio_out[3]` are 0;
  - once `done` = 1: `gpio_out` equals `gp_out` and `gpio_oe` equals `gp_oe`.
- R11: With `mask_in` tied low, `clk_en` ends as 10'h3FF. With `mask_in` tied high, `clk_en` ends as 10'h000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock; also forwarded as the shift-register clock |
| prim_rst_n | input | 1 | Primary reset, active low, asynchronous |
| sec_rst_in_n | input | 1 | Requested secondary reset, active low |
| mask_in | input | 1 | Serial mask data from the external register |
| gp_out | input | 4 | General-purpose pin values from the register file |
| gp_oe | input | 4 | General-purpose pin output enables |
| gpio_out | output | 4 | Pin output values |
| gpio_oe | output | 4 | Pin output enables |
| sec_rst_out_n | output | 1 | Extended secondary reset, active low |
| done | output | 1 | Capture complete |
| clk_en | output | 10 | Per-output clock enable (1 = running, 0 = held high) |

## Verification
Each kind of wrong internal state shows up at the ports in a predictable way:
- A sequencer counter that is off by one moves the control-pin transition or the secondary-reset release by one cycle. The bench sees this on the very cycle it happens, because it compares every output against a cycle model on every clock.
- A miscounted or misaligned shift path is invisible until completion. It then appears as a wrong `clk_en` bit, 23 cycles after the start.
- A mistake in the register-clock gating appears as an extra or missing forwarded pulse. The bench checks the pin level in the high phase of every cycle.
- Failures of the I/O handback or the reset pass-through appear on the first cycle after `done`, because the bench keeps toggling `gp_out` and `sec_rst_in_n` after that point.

// File: rtl/clkmask_pkg.sv
package clkmask_pkg;
   typedef enum logic [1:0] {
      LD_WAIT = 2'd0,
      LD_RUN  = 2'd1,
      LD_DONE = 2'd2
   } ld_state_e;
endpackage

// File: rtl/clkmask_seq.sv
module clkmask_seq
   import clkmask_pkg::*;
#(
   parameter int TOTAL  = 23,
   parameter int SETUP  = 1,
   parameter int MASK_W = 16
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      sec_rst_in_n,
   output ld_state_e state_o,
   output logic      sample_en_o,
   output logic      cap_done_o,
   output logic      ctrl_o,
   output logic      sck_o
);
   localparam int CNT_W = $clog2(TOTAL);
   localparam logic [CNT_W-1:0] LOAD_C  = CNT_W'(SETUP);
   localparam logic [CNT_W-1:0] FIRST_C = CNT_W'(SETUP + 1);
   localparam logic [CNT_W-1:0] LAST_SH = CNT_W'(SETUP + MASK_W);
   localparam logic [CNT_W-1:0] END_C   = CNT_W'(TOTAL - 1);

   if (TOTAL < SETUP + MASK_W + 2) begin : g_bad_total
      $error("clkmask_seq: TOTAL too small for SETUP and MASK_W");
   end

   ld_state_e        state_q;
   logic [CNT_W-1:0] cnt_q;
   logic             sck_want;
   logic             gate_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= LD_WAIT;
         cnt_q   <= '0;
      end else begin
         case (state_q)
            LD_WAIT: if (!sec_rst_in_n) begin
               state_q <= LD_RUN;
               cnt_q   <= '0;
            end
            LD_RUN: begin
               if (cnt_q == END_C) state_q <= LD_DONE;
               else                cnt_q   <= cnt_q + 1'b1;
            end
            default: state_q <= LD_DONE;
         endcase
      end
   end

   always_comb begin
      sck_want    = (state_q == LD_RUN) && (cnt_q >= LOAD_C) && (cnt_q <= LAST_SH);
      sample_en_o = (state_q == LD_RUN) && (cnt_q >= FIRST_C) && (cnt_q <= LAST_SH);
      cap_done_o  = (state_q == LD_RUN) && (cnt_q == END_C);
      ctrl_o      = (state_q == LD_RUN) && (cnt_q > LOAD_C);
   end

   // gate enable changes only while clk is low, so the forwarded clock has no glitch
   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) gate_q <= 1'b0;
      else        gate_q <= sck_want;
   end

   assign sck_o   = clk & gate_q;
   assign state_o = state_q;

   // R2: no start while the secondary reset request is released
   a_r2_wait: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == LD_WAIT && sec_rst_in_n) |=> (state_q == LD_WAIT));
   // R6: completion is sticky until the next primary reset
   a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == LD_DONE) |=> (state_q == LD_DONE));
   // R6: done is entered only after the last capture cycle
   a_r6_length: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(state_q == LD_DONE) |-> ($past(cnt_q) == END_C));
   // R3: after the load edge the control switches to shift
   a_r3_load_then_shift: assert property (@(posedge clk) disable iff (!rst_n)
      (sck_want && !ctrl_o) |=> ctrl_o);
endmodule

// File: rtl/clkmask_shreg.sv
module clkmask_shreg #(
   parameter int MASK_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sample_en_i,
   input  logic              cap_done_i,
   input  logic              ser_i,
   output logic [MASK_W-1:0] mask_o
);
   logic [MASK_W-1:0] sh_q;
   logic [MASK_W-1:0] mask_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q   <= '0;
         mask_q <= '0;
      end else begin
         if (sample_en_i) sh_q   <= {sh_q[MASK_W-2:0], ser_i};
         if (cap_done_i)  mask_q <= sh_q;
      end
   end

   assign mask_o = mask_q;

   // R9: the held mask moves only at completion
   a_r9_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !cap_done_i |=> $stable(mask_q));
   // R5: sampling and completion never overlap
   a_r5_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
      !(sample_en_i && cap_done_i));
endmodule

// File: rtl/clkmask_decode.sv
module clkmask_decode #(
   parameter int MASK_W  = 16,
   parameter int N_SLOTS = 4,
   parameter int N_DEV   = 6
) (
   input  logic [MASK_W-1:0]        mask_i,
   output logic [N_SLOTS+N_DEV-1:0] clk_en_o
);
   localparam int DEV_BASE = 2 * N_SLOTS;
   localparam int USED     = DEV_BASE + N_DEV;

   if (USED > MASK_W) begin : g_bad_width
      $error("clkmask_decode: slots and devices exceed MASK_W");
   end

   for (genvar s = 0; s < N_SLOTS; s++) begin : g_slot
      // a slot runs when at least one presence bit is low
      assign clk_en_o[s] = ~(mask_i[2*s] & mask_i[2*s+1]);
   end

   for (genvar d = 0; d < N_DEV; d++) begin : g_dev
      assign clk_en_o[N_SLOTS+d] = ~mask_i[DEV_BASE+d];
   end

   // R11: all used bits high turn every clock off
   always_comb begin
      a_r11_all_off: assert (!(&mask_i[USED-1:0]) || (clk_en_o == '0));
   end
endmodule

// File: rtl/clkmask_loader.sv
module clkmask_loader
   import clkmask_pkg::*;
#(
   parameter int TOTAL    = 23,
   parameter int SETUP    = 1,
   parameter int MASK_W   = 16,
   parameter int N_SLOTS  = 4,
   parameter int N_DEV    = 6,
   parameter int GPIO_W   = 4,
   parameter int SCK_PIN  = 0,
   parameter int CTRL_PIN = 2,
   localparam int NCLK    = N_SLOTS + N_DEV
) (
   input  logic              clk,
   input  logic              prim_rst_n,
   input  logic              sec_rst_in_n,
   input  logic              mask_in,
   input  logic [GPIO_W-1:0] gp_out,
   input  logic [GPIO_W-1:0] gp_oe,
   output logic [GPIO_W-1:0] gpio_out,
   output logic [GPIO_W-1:0] gpio_oe,
   output logic              sec_rst_out_n,
   output logic              done,
   output logic [NCLK-1:0]   clk_en
);
   if (SCK_PIN == CTRL_PIN || SCK_PIN >= GPIO_W || CTRL_PIN >= GPIO_W) begin : g_bad_pins
      $error("clkmask_loader: illegal pin selection");
   end

   ld_state_e         state;
   logic              sample_en;
   logic              cap_done;
   logic              ctrl;
   logic              sck;
   logic [MASK_W-1:0] mask;
   logic [GPIO_W-1:0] own_out;
   logic [GPIO_W-1:0] own_oe;

   clkmask_seq #(.TOTAL(TOTAL), .SETUP(SETUP), .MASK_W(MASK_W)) u_seq (
      .clk          (clk),
      .rst_n        (prim_rst_n),
      .sec_rst_in_n (sec_rst_in_n),
      .state_o      (state),
      .sample_en_o  (sample_en),
      .cap_done_o   (cap_done),
      .ctrl_o       (ctrl),
      .sck_o        (sck)
   );

   clkmask_shreg #(.MASK_W(MASK_W)) u_shreg (
      .clk         (clk),
      .rst_n       (prim_rst_n),
      .sample_en_i (sample_en),
      .cap_done_i  (cap_done),
      .ser_i       (mask_in),
      .mask_o      (mask)
   );

   clkmask_decode #(.MASK_W(MASK_W), .N_SLOTS(N_SLOTS), .N_DEV(N_DEV)) u_dec (
      .mask_i   (mask),
      .clk_en_o (clk_en)
   );

   for (genvar p = 0; p < GPIO_W; p++) begin : g_pin
      if (p == SCK_PIN) begin : g_sck
         assign own_out[p] = sck;
         assign own_oe[p]  = 1'b1;
      end else if (p == CTRL_PIN) begin : g_ctrl
         assign own_out[p] = ctrl;
         assign own_oe[p]  = 1'b1;
      end else begin : g_idle
         assign own_out[p] = 1'b0;
         assign own_oe[p]  = 1'b0;
      end
   end

   assign done          = (state == LD_DONE);
   assign gpio_out      = done ? gp_out : own_out;
   assign gpio_oe       = done ? gp_oe  : own_oe;
   assign sec_rst_out_n = done & sec_rst_in_n;

   // R9: clock enables move only on the completing edge
   a_r9_en_hold: assert property (@(posedge clk) disable iff (!prim_rst_n)
      !cap_done |=> $stable(clk_en));
   // R10: pins belong to the register file after completion
   a_r10_handback: assert property (@(posedge clk) disable iff (!prim_rst_n)
      done |-> (gpio_oe == gp_oe && gpio_out == gp_out));
   // R6: downstream reset held while capture is unfinished
   a_r6_rst_held: assert property (@(posedge clk) disable iff (!prim_rst_n)
      !done |-> !sec_rst_out_n);
endmodule

// File: tb/clkmask_loader_tb.sv
module clkmask_loader_tb;
   logic       clk = 1'b0;
   logic       prim_rst_n = 1'b0;
   logic       sec_rst_in_n = 1'b0;
   logic       mask_in = 1'b0;
   logic [3:0] gp_out = 4'h0;
   logic [3:0] gp_oe = 4'h0;
   logic [3:0] gpio_out, gpio_oe;
   logic       sec_rst_out_n, done;
   logic [9:0] clk_en;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   clkmask_loader u_dut (
      .clk(clk), .prim_rst_n(prim_rst_n), .sec_rst_in_n(sec_rst_in_n),
      .mask_in(mask_in), .gp_out(gp_out), .gp_oe(gp_oe),
      .gpio_out(gpio_out), .gpio_oe(gpio_oe),
      .sec_rst_out_n(sec_rst_out_n), .done(done), .clk_en(clk_en)
   );

   // external parallel-in/serial-out register
   logic        fitted = 1'b0;
   logic [15:0] pattern = 16'h0;
   logic [15:0] ext_sr = 16'h0;
   logic        ctrl_prev = 1'b0;

   always @(negedge clk) ctrl_prev = gpio_out[2];

   always @(posedge gpio_out[0]) begin
      if (fitted) begin
         if (!ctrl_prev) ext_sr = pattern;
         else            ext_sr = {ext_sr[14:0], 1'b0};
         #1 mask_in = ext_sr[15];
      end
   end

   // behavioural reference model
   int          m_phase = 0;   // 0 wait, 1 run, 2 done
   int          m_cyc = 0;
   logic [15:0] m_mask = 16'h0;
   logic        m_sck_exp = 1'b0;
   logic        m_tied = 1'b0;

   function automatic logic [9:0] expect_en(input logic [15:0] m);
      logic [9:0] e;
      for (int i = 0; i < 4; i++) e[i] = !(m[2*i] && m[2*i+1]);
      for (int j = 0; j < 6; j++) e[4+j] = !m[8+j];
      return e;
   endfunction

   function automatic logic [15:0] source_mask();
      if (fitted) return pattern;
      return mask_in ? 16'hFFFF : 16'h0000;
   endfunction

   always @(posedge clk or negedge prim_rst_n) begin
      if (!prim_rst_n) begin
         m_phase   <= 0;
         m_cyc     <= 0;
         m_mask    <= 16'h0;
         m_sck_exp <= 1'b0;
      end else begin
         m_sck_exp <= (m_phase == 1) && (m_cyc >= 1) && (m_cyc <= 17);
         if (m_phase == 0 && !sec_rst_in_n) begin
            m_phase <= 1;
            m_cyc   <= 0;
         end else if (m_phase == 1) begin
            if (m_cyc == 22) begin
               m_phase <= 2;
               m_mask  <= source_mask();
            end else m_cyc <= m_cyc + 1;
         end
      end
   end

   task automatic check(input string tag, input string what, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   // per-cycle comparison in the low phase
   always @(negedge clk) begin
      if (!prim_rst_n) begin
         check("R1", "sec_rst_out_n", sec_rst_out_n, 0);
         check("R1", "done", done, 0);
         check("R1", "clk_en", clk_en, 10'h3FF);
         check("R1", "gpio_oe", gpio_oe, 4'b0101);
         check("R1", "gpio_out", gpio_out, 0);
      end else if (m_phase != 2) begin
         check(m_phase == 0 ? "R2" : "R6", "done", done, 0);
         check("R6", "sec_rst_out_n", sec_rst_out_n, 0);
         check("R3", "ctrl pin", gpio_out[2], (m_phase == 1 && m_cyc >= 2) ? 1 : 0);
         check("R9", "clk_en before completion", clk_en, 10'h3FF);
         check("R10", "gpio_oe while owned", gpio_oe, 4'b0101);
         check("R10", "unused pins", {gpio_out[3], gpio_out[1]}, 0);
      end else begin
         check("R6", "done", done, 1);
         check("R6", "sec_rst_out_n follows request", sec_rst_out_n, sec_rst_in_n);
         check("R7", "slot enables", clk_en[3:0], expect_en(m_mask) & 4'hF);
         check("R8", "device enables", clk_en[9:4], expect_en(m_mask) >> 4);
         if (fitted) check("R5", "captured mask decode", clk_en, expect_en(m_mask));
         if (m_tied) check("R11", "tied input decode", clk_en, mask_in ? 10'h000 : 10'h3FF);
         check("R10", "gpio_out handback", gpio_out, gp_out);
         check("R10", "gpio_oe handback", gpio_oe, gp_oe);
      end
   end

   // forwarded register clock checked in the high phase
   always @(posedge clk) begin
      #1;
      if (prim_rst_n && m_phase != 2 && !(m_phase == 0 && m_sck_exp == 0 && done))
         check("R4", "register clock pin", gpio_out[0], m_sck_exp);
   end

   task automatic cycles(input int n);
      repeat (n) @(posedge clk);
      #3;
   endtask

   task automatic run(input logic fit, input logic [15:0] pat, input logic tie,
                      input int wait_hi);
      @(posedge clk); #3;
      prim_rst_n   = 1'b0;
      sec_rst_in_n = 1'b0;
      fitted       = fit;
      pattern      = pat;
      m_tied       = !fit;
      mask_in      = fit ? 1'b0 : tie;
      cycles(3);
      if (wait_hi > 0) sec_rst_in_n = 1'b1;
      prim_rst_n = 1'b1;
      cycles(wait_hi);            // R2: wait while request released
      sec_rst_in_n = 1'b0;
      cycles(26);
      // R6/R10: pass-through once complete
      for (int k = 0; k < 6; k++) begin
         gp_out       = 4'(k * 5 + 3);
         gp_oe        = 4'(k * 3 + 1);
         sec_rst_in_n = k[0];
         cycles(1);
      end
      sec_rst_in_n = 1'b0;
      cycles(2);
   endtask

   initial begin
      cycles(2);
      run(1'b0, 16'h0000, 1'b0, 0);   // R11 tied low
      run(1'b0, 16'h0000, 1'b1, 0);   // R11 tied high
      run(1'b1, 16'hA5C3, 1'b0, 0);   // R5 R7 R8
      run(1'b1, 16'h3F3E, 1'b0, 6);   // R2 delayed start
      run(1'b1, 16'h0A5A, 1'b0, 0);   // R8 reserved clear
      run(1'b1, 16'hCA5A, 1'b0, 0);   // R8 reserved set, same enables
      run(1'b1, 16'h8001, 1'b0, 2);   // R5 end bits
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule